// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block is the register and FIFO front-end of a block cipher accelerator. Software sees a 32-bit register window with control, status, interrupt flag and interrupt enable registers, a write-only key bank of eight words, and a single FIFO port. Words written to the FIFO port assemble a 128-bit input block. Reads of the same port drain a 128-bit result one word at a time.

An operation starts in one of two ways: software sets the start bit in the control register, or the fourth word arrives at the FIFO port. The front-end then passes the block, the key trimmed to the selected length, the key size and an encrypt/decrypt flag to an external cipher core. It sends a one-cycle start pulse and waits for a one-cycle done pulse that returns the result. A third operation type decrypts with the key latched by the last ordinary encrypt or decrypt. This lets software change the key bank without losing the key of the previous operation.

The register offsets are CTRL 0x00, STATUS 0x04, INTFLAG 0x08, INTEN 0x0C, FIFO 0x10 and KEY 0x20 to 0x3C. The CTRL bits are enable at bit 0, start at bit 1, input flush at bit 2, output flush at bit 3, key size at bits 7:6 and operation type at bits 9:8. The STATUS bits are input full at bit 0, input empty at bit 1, output full at bit 2, output empty at bit 3 and busy at bit 4. The done flag is bit 0 of both INTFLAG and INTEN.

Top module: `blkcipher_regfront`

## Requirements
- R1: STATUS reports its flags from the word counts. Input empty is set when no input words are held. Output full is set when four result words are held. Output empty is set when none are held. Input full never stays set, because the fourth word starts an operation.
- R2: The n-th word written to FIFO (n = 0..3, counted since the last start or flush) becomes bits 32n+31:32n of the block. The fourth word clears the input count and starts an operation.
- R3: A FIFO read with four result words held returns result bits 31:0, the next read returns bits 63:32, and so on. Each read that returns data decrements the count and clears the done flag. A read with no words held returns 0 and changes nothing.
- R4: A CTRL write with bit 2 set clears the input count. A CTRL write with bit 3 set clears the output count. Neither bit is stored: both read back as 0.
- R5: The enable bit, once written 1, reads back 1 until reset, even after 0 is written to it. The start bit reads back as 0.
- R6: Key size 0 passes key bits 127:0 to the core, size 1 passes bits 191:0, and sizes 2 and 3 pass all 256 bits. The unused upper bits are driven as 0, and the core key-size output carries the field.
- R7: Type 0 requests encryption and type 1 requests decryption. Both use the current key and latch it with its size. Types 2 and 3 request decryption with the latched key and size, whatever the key bank now holds.
- R8: A write to KEY offset 0x20+4w loads key bits 32w+31:32w, so the lowest address holds the least significant word. Key words read back as 0.
- R9: A done pulse loads the result, sets the output count to four words and sets the done flag. The interrupt output equals done flag AND done enable. Writing 1 to INTFLAG bit 0 clears the flag.
- R10: Accesses to undefined or non-word-aligned addresses have no effect and read as 0. Reset clears every register, both counts, the key bank and the latched key.
- R11: From a start pulse until the done pulse, STATUS bit 4 is set and FIFO writes and start requests are ignored. The start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | WORD_W | Write data |
| busRdata | output | WORD_W | Read data, valid in the access cycle |
| irqOut | output | 1 | Interrupt request |
| coreStart | output | 1 | One-cycle start pulse to the cipher core |
| coreBlock | output | BLOCK_WORDS*WORD_W | Input block |
| coreKey | output | KEY_WORDS*WORD_W | Key trimmed to the selected size |
| coreKeySize | output | 2 | Key-size code |
| coreDecrypt | output | 1 | 1 requests decryption |
| coreDone | input | 1 | One-cycle done pulse from the core |
| coreResult | input | BLOCK_WORDS*WORD_W | Result block, valid with coreDone |

## Verification
The bench drains results through a read after the count has already reached zero. A design that underflows the count would return a stale word there and flip output-full back on. It changes the key bank between a type-1 and a type-2 operation. A design that rereads the bank for type 2 would send the new key. It writes FIFO and start while the core is busy. A design without the hold-off would corrupt the block or pulse start twice. Writing zero to CTRL checks that the enable bit stays set. A CTRL write with both flush bits checks that neither bit is stored. A start bit sent to a misaligned address checks that it launches nothing.

// File: rtl/aesfe_pkg.sv
package aesfe_pkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_FLAG  = 'h08;
  localparam int OFF_IEN   = 'h0C;
  localparam int OFF_FIFO  = 'h10;
  localparam int OFF_KEY   = 'h20;

  localparam int CB_EN     = 0;
  localparam int CB_START  = 1;
  localparam int CB_IFLUSH = 2;
  localparam int CB_OFLUSH = 3;
  localparam int CB_SIZE   = 6;
  localparam int CB_TYPE   = 8;

  localparam int SB_IN_FULL   = 0;
  localparam int SB_IN_EMPTY  = 1;
  localparam int SB_OUT_FULL  = 2;
  localparam int SB_OUT_EMPTY = 3;
  localparam int SB_BUSY      = 4;

  typedef struct packed {
    logic       inWr;
    logic [3:0] inIdx;
    logic       keyWr;
    logic [3:0] keyIdx;
    logic       launch;
    logic [1:0] opType;
    logic [1:0] opSize;
    logic       resLoad;
    logic [3:0] rdIdx;
  } feStrobes_t;
endpackage

// File: rtl/aesfe_ctrl.sv
module aesfe_ctrl
  import aesfe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_WORDS = 4,
  parameter int KEY_WORDS   = 8,
  parameter int WORD_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              coreDone,
  input  logic [WORD_W-1:0] fifoWord,
  output logic [WORD_W-1:0] busRdata,
  output logic              irqOut,
  output feStrobes_t        st
);
  localparam int CNT_W    = $clog2(BLOCK_WORDS + 1);
  localparam int KEY_SPAN = KEY_WORDS * 4;

  logic [CNT_W-1:0] inCnt, outCnt;
  logic             ctrlEn, busy, doneFlag, doneIen;
  logic [1:0]       ctrlSize, ctrlType;

  logic             aligned, isWr, isRd;
  logic             hitCtrl, hitStat, hitFlag, hitIen, hitFifo, hitKey;
  logic [ADDR_W-1:0] keyOff;
  logic             fifoPush, lastPush, ctrlStart, launch, pop, ctrlWr;
  logic             unusedWdata;

  assign unusedWdata = ^{busWdata[WORD_W-1:10], busWdata[5:4]};

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    isWr    = busSel & busWrite & aligned;
    isRd    = busSel & ~busWrite & aligned;
    hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
    hitStat = (busAddr == ADDR_W'(OFF_STAT));
    hitFlag = (busAddr == ADDR_W'(OFF_FLAG));
    hitIen  = (busAddr == ADDR_W'(OFF_IEN));
    hitFifo = (busAddr == ADDR_W'(OFF_FIFO));
    hitKey  = (busAddr >= ADDR_W'(OFF_KEY)) && (busAddr < ADDR_W'(OFF_KEY + KEY_SPAN));
    keyOff  = busAddr - ADDR_W'(OFF_KEY);
  end

  assign ctrlWr    = isWr & hitCtrl;
  assign fifoPush  = isWr & hitFifo & ~busy;
  assign lastPush  = fifoPush && (inCnt == CNT_W'(BLOCK_WORDS - 1));
  assign ctrlStart = ctrlWr & busWdata[CB_START] & ~busy;
  assign launch    = ctrlStart | lastPush;
  assign pop       = isRd & hitFifo & (outCnt != '0);

  always_comb begin
    st         = '0;
    st.inWr    = fifoPush;
    st.inIdx   = 4'(inCnt);
    st.keyWr   = isWr & hitKey;
    st.keyIdx  = 4'(keyOff >> 2);
    st.launch  = launch;
    st.opType  = ctrlStart ? busWdata[CB_TYPE +: 2] : ctrlType;
    st.opSize  = ctrlStart ? busWdata[CB_SIZE +: 2] : ctrlSize;
    st.resLoad = coreDone;
    st.rdIdx   = 4'(CNT_W'(BLOCK_WORDS) - outCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlSize <= 2'b00;
      ctrlType <= 2'b00;
      inCnt    <= '0;
      outCnt   <= '0;
      doneFlag <= 1'b0;
      doneIen  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlEn   <= ctrlEn | busWdata[CB_EN];
        ctrlSize <= busWdata[CB_SIZE +: 2];
        ctrlType <= busWdata[CB_TYPE +: 2];
      end

      if (ctrlWr && busWdata[CB_IFLUSH]) inCnt <= '0;
      else if (lastPush)                 inCnt <= '0;
      else if (fifoPush)                 inCnt <= inCnt + 1'b1;

      if (coreDone)                           outCnt <= CNT_W'(BLOCK_WORDS);
      else if (ctrlWr && busWdata[CB_OFLUSH]) outCnt <= '0;
      else if (pop)                           outCnt <= outCnt - 1'b1;

      if (coreDone)                            doneFlag <= 1'b1;
      else if (pop)                            doneFlag <= 1'b0;
      else if (isWr && hitFlag && busWdata[0]) doneFlag <= 1'b0;

      if (isWr && hitIen) doneIen <= busWdata[0];

      if (launch)        busy <= 1'b1;
      else if (coreDone) busy <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (isRd) begin
      if (hitCtrl) begin
        busRdata[CB_EN]        = ctrlEn;
        busRdata[CB_SIZE +: 2] = ctrlSize;
        busRdata[CB_TYPE +: 2] = ctrlType;
      end else if (hitStat) begin
        busRdata[SB_IN_FULL]   = (inCnt >= CNT_W'(BLOCK_WORDS));
        busRdata[SB_IN_EMPTY]  = (inCnt == '0);
        busRdata[SB_OUT_FULL]  = (outCnt >= CNT_W'(BLOCK_WORDS));
        busRdata[SB_OUT_EMPTY] = (outCnt == '0);
        busRdata[SB_BUSY]      = busy;
      end else if (hitFlag) begin
        busRdata[0] = doneFlag;
      end else if (hitIen) begin
        busRdata[0] = doneIen;
      end else if (hitFifo && outCnt != '0) begin
        busRdata = fifoWord;
      end
    end
  end

  assign irqOut = doneFlag & doneIen;

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy); // R11
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !coreDone) |=> busy); // R11
  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> (outCnt == CNT_W'(BLOCK_WORDS)) && doneFlag); // R9
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEn |=> ctrlEn); // R5
  AST_IN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inCnt < CNT_W'(BLOCK_WORDS)); // R2
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !coreDone) |=> !doneFlag); // R3
endmodule

// File: rtl/aesfe_data.sv
module aesfe_data
  import aesfe_pkg::*;
#(
  parameter int BLOCK_WORDS = 4,
  parameter int KEY_WORDS   = 8,
  parameter int WORD_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  feStrobes_t                    st,
  input  logic [WORD_W-1:0]             busWdata,
  input  logic [BLOCK_WORDS*WORD_W-1:0] coreResult,
  output logic [WORD_W-1:0]             fifoWord,
  output logic                          coreStart,
  output logic [BLOCK_WORDS*WORD_W-1:0] coreBlock,
  output logic [KEY_WORDS*WORD_W-1:0]   coreKey,
  output logic [1:0]                    coreKeySize,
  output logic                          coreDecrypt
);
  localparam int BLOCK_W   = BLOCK_WORDS * WORD_W;
  localparam int KEY_W     = KEY_WORDS * WORD_W;
  localparam int WORDS_S0  = KEY_WORDS / 2;
  localparam int WORDS_S1  = (KEY_WORDS * 3) / 4;

  logic [KEY_W-1:0]   keyVec, keyMask, alignedKey, keptKey;
  logic [1:0]         keptSize;
  logic [BLOCK_W-1:0] dataVec, resultVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyVec  <= '0;
      dataVec <= '0;
    end else begin
      for (int w = 0; w < KEY_WORDS; w++)
        if (st.keyWr && st.keyIdx == 4'(w)) keyVec[w*WORD_W +: WORD_W] <= busWdata;
      for (int w = 0; w < BLOCK_WORDS; w++)
        if (st.inWr && st.inIdx == 4'(w)) dataVec[w*WORD_W +: WORD_W] <= busWdata;
    end
  end

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_mask
    logic useWord;
    always_comb begin
      case (st.opSize)
        2'd0:    useWord = (w < WORDS_S0);
        2'd1:    useWord = (w < WORDS_S1);
        default: useWord = 1'b1;
      endcase
    end
    assign keyMask[w*WORD_W +: WORD_W] = {WORD_W{useWord}};
  end

  assign alignedKey = keyVec & keyMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keptKey     <= '0;
      keptSize    <= 2'b00;
      coreKey     <= '0;
      coreKeySize <= 2'b00;
      coreDecrypt <= 1'b0;
      coreStart   <= 1'b0;
      resultVec   <= '0;
    end else begin
      coreStart <= st.launch;
      if (st.launch) begin
        if (st.opType[1]) begin
          coreKey     <= keptKey;
          coreKeySize <= keptSize;
          coreDecrypt <= 1'b1;
        end else begin
          coreKey     <= alignedKey;
          coreKeySize <= st.opSize;
          coreDecrypt <= st.opType[0];
          keptKey     <= alignedKey;
          keptSize    <= st.opSize;
        end
      end
      if (st.resLoad) resultVec <= coreResult;
    end
  end

  assign coreBlock = dataVec;

  always_comb begin
    fifoWord = '0;
    for (int w = 0; w < BLOCK_WORDS; w++)
      if (st.rdIdx == 4'(w)) fifoWord = resultVec[w*WORD_W +: WORD_W];
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart); // R11
  AST_KEPT_DECRYPTS: assert property (@(posedge clk) disable iff (!rstN)
    (st.launch && st.opType[1]) |=> (coreStart && coreDecrypt)); // R7
endmodule

// File: rtl/blkcipher_regfront.sv
module blkcipher_regfront
  import aesfe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_WORDS = 4,
  parameter int KEY_WORDS   = 8,
  parameter int WORD_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [WORD_W-1:0]             busWdata,
  output logic [WORD_W-1:0]             busRdata,
  output logic                          irqOut,
  output logic                          coreStart,
  output logic [BLOCK_WORDS*WORD_W-1:0] coreBlock,
  output logic [KEY_WORDS*WORD_W-1:0]   coreKey,
  output logic [1:0]                    coreKeySize,
  output logic                          coreDecrypt,
  input  logic                          coreDone,
  input  logic [BLOCK_WORDS*WORD_W-1:0] coreResult
);
  feStrobes_t        st;
  logic [WORD_W-1:0] fifoWord;

  aesfe_ctrl #(
    .ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS), .KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .coreDone(coreDone), .fifoWord(fifoWord),
    .busRdata(busRdata), .irqOut(irqOut), .st(st)
  );

  aesfe_data #(
    .BLOCK_WORDS(BLOCK_WORDS), .KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata), .coreResult(coreResult),
    .fifoWord(fifoWord), .coreStart(coreStart), .coreBlock(coreBlock), .coreKey(coreKey),
    .coreKeySize(coreKeySize), .coreDecrypt(coreDecrypt)
  );
endmodule

// File: tb/test_blkcipher_regfront.sv
module test_blkcipher_regfront;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         irqOut, coreStart, coreDecrypt;
  logic [127:0] coreBlock;
  logic [255:0] coreKey;
  logic [1:0]   coreKeySize;
  logic         coreDone = 1'b0;
  logic [127:0] coreResult = '0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  blkcipher_regfront i_blkcipher_regfront (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .coreStart(coreStart),
    .coreBlock(coreBlock), .coreKey(coreKey), .coreKeySize(coreKeySize),
    .coreDecrypt(coreDecrypt), .coreDone(coreDone), .coreResult(coreResult)
  );

  // behavioural reference model
  logic         mEn, mFlag, mIen, mBusy, mStart, mExpDec;
  logic [1:0]   mSize, mType, mKeptSize, mExpSize;
  int           mIn, mOut;
  logic [31:0]  mData [4];
  logic [31:0]  mKey [8];
  logic [127:0] mRes, mExpBlock;
  logic [255:0] mKept, mExpKey;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] modelKey(input logic [1:0] sz);
    logic [255:0] k;
    int nw;
    nw = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 6 : 8;
    k = '0;
    for (int w = 0; w < 8; w++) if (w < nw) k[32*w +: 32] = mKey[w];
    return k;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] == 2'b00) begin
      case (a)
        8'h00: begin r[0] = mEn; r[7:6] = mSize; r[9:8] = mType; end
        8'h04: begin
          r[0] = (mIn >= 4); r[1] = (mIn == 0); r[2] = (mOut >= 4);
          r[3] = (mOut == 0); r[4] = mBusy;
        end
        8'h08: r[0] = mFlag;
        8'h0C: r[0] = mIen;
        8'h10: if (mOut > 0) r = mRes[32*(4-mOut) +: 32];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin : model
    logic       doLaunch;
    logic [1:0] lt, ls;
    if (!rstN) begin
      mEn = 0; mFlag = 0; mIen = 0; mBusy = 0; mStart = 0; mExpDec = 0;
      mSize = 0; mType = 0; mKeptSize = 0; mExpSize = 0; mIn = 0; mOut = 0;
      for (int i = 0; i < 4; i++) mData[i] = '0;
      for (int i = 0; i < 8; i++) mKey[i] = '0;
      mRes = '0; mExpBlock = '0; mKept = '0; mExpKey = '0;
    end else begin
      doLaunch = 0; lt = mType; ls = mSize; mStart = 0;
      if (busSel && busAddr[1:0] == 2'b00) begin
        if (busWrite) begin
          case (busAddr)
            8'h00: begin
              if (busWdata[3]) mOut = 0;
              if (busWdata[2]) mIn = 0;
              if (busWdata[1] && !mBusy) begin
                doLaunch = 1; lt = busWdata[9:8]; ls = busWdata[7:6];
              end
              mEn = mEn | busWdata[0]; mSize = busWdata[7:6]; mType = busWdata[9:8];
            end
            8'h08: if (busWdata[0]) mFlag = 0;
            8'h0C: mIen = busWdata[0];
            8'h10: if (!mBusy) begin
              mData[mIn] = busWdata; mIn++;
              if (mIn == 4) begin mIn = 0; doLaunch = 1; end
            end
            default: if (busAddr >= 8'h20 && busAddr < 8'h40) mKey[(busAddr - 8'h20) >> 2] = busWdata;
          endcase
        end else if (busAddr == 8'h10 && mOut > 0) begin
          mOut--; mFlag = 0;
        end
      end
      if (doLaunch) begin
        if (lt >= 2) begin
          mExpKey = mKept; mExpSize = mKeptSize; mExpDec = 1;
        end else begin
          mExpKey = modelKey(ls); mExpSize = ls; mExpDec = lt[0];
          mKept = mExpKey; mKeptSize = ls;
        end
        mExpBlock = {mData[3], mData[2], mData[1], mData[0]};
        mBusy = 1; mStart = 1;
      end
      if (coreDone) begin
        mRes = coreResult; mOut = 4; mFlag = 1; mBusy = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      chk(irqOut === (mFlag & mIen), "R9 irq", 256'(irqOut), 256'(mFlag & mIen));
      chk(coreStart === mStart, "R11 start pulse", 256'(coreStart), 256'(mStart));
      if (coreStart) begin
        chk(coreKey === mExpKey, "R6 R7 R8 core key", coreKey, mExpKey);
        chk(coreKeySize === mExpSize, "R6 key size", 256'(coreKeySize), 256'(mExpSize));
        chk(coreDecrypt === mExpDec, "R7 direction", 256'(coreDecrypt), 256'(mExpDec));
        chk(coreBlock === mExpBlock, "R2 block", 256'(coreBlock), 256'(mExpBlock));
      end
    end
  end

  // core stub
  int lat = 0;
  logic [127:0] stubBlk;
  logic [255:0] stubKey;
  logic         stubDec;
  always @(negedge clk) begin
    coreDone = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        coreDone = 1'b1;
        coreResult = stubBlk ^ stubKey[127:0] ^ stubKey[255:128] ^
                     (stubDec ? {4{32'hA5A5_5A5A}} : 128'h0);
      end
    end
    if (coreStart) begin
      stubBlk = coreBlock; stubKey = coreKey; stubDec = coreDecrypt; lat = 3;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1;
    e = expRead(a);
    chk(busRdata === e, tag, 256'(busRdata), 256'(e));
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic waitDone();
    while (mBusy) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R10 reset state, R1 empty flags
    rd(8'h00, "R10 reset ctrl");
    rd(8'h04, "R1 R10 reset status");
    rd(8'h08, "R10 reset flag");
    rd(8'h0C, "R10 reset inten");
    rd(8'h10, "R10 reset fifo");
    // R8 key bank
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(4*i), 32'h1000_0001 * (i + 1) ^ 32'h0F0F_0000);
    rd(8'h24, "R8 key readback zero");
    // R5 enable, R2 automatic start
    wr(8'h00, 32'h1);
    rd(8'h00, "R5 ctrl enable");
    wr(8'h10, 32'hAAAA_0000);
    rd(8'h04, "R1 partial input");
    wr(8'h10, 32'hBBBB_1111);
    wr(8'h10, 32'hCCCC_2222);
    wr(8'h10, 32'hDDDD_3333);
    rd(8'h04, "R11 busy flag");
    waitDone();
    rd(8'h04, "R1 output full");
    rd(8'h08, "R9 done flag");
    for (int i = 0; i < 4; i++) rd(8'h10, "R3 drain order");
    rd(8'h10, "R3 underflow read");
    rd(8'h04, "R3 R1 output empty");
    rd(8'h08, "R3 flag cleared by pop");
    // R6 key sizes
    wr(8'h00, 32'h1 | 32'h2 | (32'd1 << 6)); waitDone();
    wr(8'h00, 32'h1 | 32'h2 | (32'd2 << 6)); waitDone();
    wr(8'h00, 32'h1 | 32'h2 | (32'd3 << 6)); waitDone();
    rd(8'h00, "R6 size field");
    // R7 decrypt, then kept key after bank change
    wr(8'h00, 32'h1 | 32'h2 | (32'd1 << 8) | (32'd1 << 6)); waitDone();
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h34, 32'h0BAD_CAFE);
    wr(8'h00, 32'h1 | 32'h2 | (32'd2 << 8)); waitDone();
    wr(8'h00, 32'h1 | 32'h2 | (32'd3 << 8) | (32'd2 << 6)); waitDone();
    wr(8'h00, 32'h1 | 32'h2); waitDone();
    rd(8'h10, "R7 result word");
    // R9 interrupt
    wr(8'h0C, 32'h1);
    rd(8'h0C, "R9 enable readback");
    wr(8'h00, 32'h1 | 32'h2); waitDone();
    @(negedge clk);
    chk(irqOut === 1'b1, "R9 irq after done", 256'(irqOut), 256'(1));
    wr(8'h08, 32'h1);
    rd(8'h08, "R9 flag w1c");
    wr(8'h0C, 32'h0);
    // R11 hold-off while busy
    wr(8'h00, 32'h1 | 32'h2);
    wr(8'h10, 32'h5555_5555);
    wr(8'h00, 32'h1 | 32'h2);
    rd(8'h04, "R11 busy and input empty");
    waitDone();
    rd(8'h04, "R11 ignored fifo write");
    // R4 flushes
    wr(8'h10, 32'h1234_5678);
    wr(8'h10, 32'h9ABC_DEF0);
    rd(8'h04, "R4 before input flush");
    wr(8'h00, 32'h1 | 32'h4);
    rd(8'h04, "R4 after input flush");
    wr(8'h00, 32'h1 | 32'h8 | 32'h4);
    rd(8'h00, "R4 flush bits not stored");
    rd(8'h04, "R4 after output flush");
    rd(8'h10, "R4 fifo empty after flush");
    // R5 sticky enable
    wr(8'h00, 32'h0);
    rd(8'h00, "R5 enable sticky");
    // R10 undefined and misaligned
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h01, 32'h2);
    wr(8'h0D, 32'h1);
    rd(8'h44, "R10 undefined read");
    rd(8'h02, "R10 misaligned read");
    rd(8'h04, "R10 no start from misaligned");
    rd(8'h0C, "R10 inten untouched");
    repeat (5) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule